// File: doc/BRIEF.md
# Predicated Condition-Field Vector Sequencer

This block runs a short vector loop, from one to eight elements long, over a group of adjacent 4-bit condition fields that starts at a chosen base field. It handles one element per clock. Unlike an ordinary vector loop, the integer side of the loop stays on a single 64-bit word the whole time. Each element packs bits into that word or unpacks bits from it, so the loop never advances to a new register.

The loop runs in one of two directions.

- **Gather:** each field is compared against a mask and a mode pattern. The one-bit outcome is replicated across a lane of 1, 2, 4 or 8 bits. Lanes are placed from bit 0 upward inside an integer element of 8, 16, 32 or 64 bits.
- **Expand:** each element reads its lane from the integer source. The lane and a predicate bit decide the value written back to the field.

Elements that do not fit in the chosen element width are discarded, and an overflow flag is raised.

The block takes its configuration when start is pulsed in the idle state. It then drives a one-field-per-cycle write port during expand, and gives a one-cycle done pulse with the final integer word. Instruction decode and the condition-field storage itself are outside the block. The storage is visible through a flat read bus and is updated from the write port.

Top module: `cfv_seq`

## Requirements
- R1: A start sampled while idle begins an operation. Busy is high for exactly VL cycles, with element i processed in the i-th of them. Done is high for the single cycle that follows, and busy is low in that cycle.
- R2: A start sampled while busy is ignored. The running operation's writes, result and flag are unchanged, and no new operation begins after it.
- R3: Lane width P is 1, 2, 4 or 8 for pack_sel codes 0, 1, 2 and 3. Element width EW is 8, 16, 32 or 64 for ew_sel codes 0, 1, 2 and 3. ovf is set from the cycle after start until the next start exactly when VL > EW/P. Elements with index i >= EW/P produce no write and no integer change.
- R4: Gather (dir_expand = 0). The test of field f is 1 when any bit of mask & ~(f ^ mode) is set. For an element with predicate bit 1, lane bits [i*P +: P] of the result are all set to that test value.
- R5: Gather result bits at or above min(VL, EW/P)*P are 0. This includes every bit at or above EW.
- R6: Gather, predicate bit 0. With zero_en = 1 the element's lane is 0. With zero_en = 0 the lane keeps the corresponding int_src bits.
- R7: Expand (dir_expand = 1), predicate bit 1. The lane int_src[i*P +: P] is read. The field is written with mask & mode when any lane bit is set, and with mask & ~mode when the lane is zero.
- R8: Expand, predicate bit 0. With zero_en = 1 the field is written with 0. With zero_en = 0 there is no write and the field keeps its value.
- R9: Element i addresses field (base + i) mod NFLD and uses predicate bit i (LSB0).
- R10: In expand mode int_res reads 0 during the operation and at done. In gather mode int_res holds the packed word at done.
- R11: After reset busy, done, fw_en, ovf and int_res are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| dir_expand | input | 1 | 0 = gather fields into integer, 1 = expand integer into fields |
| base_fld | input | 4 | First field index |
| vl_m1 | input | 3 | Vector length minus one |
| mask | input | 4 | Field bit mask |
| mode | input | 4 | Field mode pattern |
| pack_sel | input | 2 | Lane width code |
| ew_sel | input | 2 | Integer element width code |
| pred | input | 8 | Predicate, bit i for element i |
| zero_en | input | 1 | Zeroing of predicated-off elements |
| int_src | input | 64 | Integer source word |
| fld_all | input | 64 | All fields, field k at bits [4k +: 4] |
| busy | output | 1 | Operation in progress |
| fw_en | output | 1 | Field write strobe |
| fw_idx | output | 4 | Field write index |
| fw_data | output | 4 | Field write value |
| int_res | output | 64 | Integer result word |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Elements were discarded for lack of room |

## Verification
The bench builds the block with its default parameters: 16 fields, a 64-bit word and loops of up to eight elements. With that configuration, the sweep reaches every pack code, every element-width code, every VL, both directions and both zeroing settings. This covers every overflow boundary, from all eight elements fitting down to only one fitting. Base fields step through all sixteen positions, so the index wrap past the last field is also exercised. Directed runs reproduce the two-element expand case with a zero source and check that a start issued mid-loop is ignored.

// File: rtl/cfv_pkg.sv
package cfv_pkg;
  typedef enum logic {DIR_GATHER = 1'b0, DIR_EXPAND = 1'b1} dir_e;

  function automatic logic [7:0] lane_mask(input logic [1:0] sel);
    case (sel)
      2'd0: lane_mask = 8'h01;
      2'd1: lane_mask = 8'h03;
      2'd2: lane_mask = 8'h0F;
      default: lane_mask = 8'hFF;
    endcase
  endfunction

  // log2 of how many lanes fit in the element
  function automatic logic [3:0] cap_log2(input logic [1:0] ew_sel,
                                          input logic [1:0] pack_sel);
    cap_log2 = 4'd3 + {2'b00, ew_sel} - {2'b00, pack_sel};
  endfunction
endpackage

// File: rtl/cfv_ctrl.sv
module cfv_ctrl #(
  parameter int MAXVL = 8,
  localparam int VLW = $clog2(MAXVL)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [VLW-1:0] vl_m1,
  output logic           load,
  output logic           busy,
  output logic [VLW-1:0] idx,
  output logic           done
);
  logic [VLW-1:0] last_q;

  assign load = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      idx    <= '0;
      done   <= 1'b0;
      last_q <= '0;
    end else begin
      done <= 1'b0;
      if (load) begin
        busy   <= 1'b1;
        idx    <= '0;
        last_q <= vl_m1;
      end else if (busy) begin
        if (idx == last_q) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cfv_elem.sv
module cfv_elem
  import cfv_pkg::*;
#(
  parameter int FW    = 4,
  parameter int XLEN  = 64,
  parameter int MAXVL = 8,
  localparam int VLW  = $clog2(MAXVL)
) (
  input  dir_e           dir,
  input  logic [1:0]     pack_sel,
  input  logic [1:0]     ew_sel,
  input  logic [VLW-1:0] idx,
  input  logic           pred_bit,
  input  logic           zero_en,
  input  logic [FW-1:0]  mask,
  input  logic [FW-1:0]  mode,
  input  logic [FW-1:0]  fld,
  input  logic [XLEN-1:0] src,
  output logic           wr_en,
  output logic [FW-1:0]  wr_data,
  output logic           ins_en,
  output logic           ins_bit
);
  logic           in_range;
  logic [VLW+2:0] shamt;
  logic [XLEN-1:0] shifted;
  logic           lane_nz;
  logic           hit;
  logic           act;

  assign in_range = (idx >> cap_log2(ew_sel, pack_sel)) == '0;
  assign shamt    = {3'b000, idx} << pack_sel;
  assign shifted  = src >> shamt;
  assign lane_nz  = |(shifted[7:0] & lane_mask(pack_sel));
  assign hit      = |(mask & ~(fld ^ mode));
  assign act      = in_range && (pred_bit || zero_en);

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    ins_en  = 1'b0;
    ins_bit = 1'b0;
    if (dir == DIR_EXPAND) begin
      wr_en = act;
      if (pred_bit) wr_data = mask & (lane_nz ? mode : ~mode);
    end else begin
      ins_en  = act;
      ins_bit = pred_bit && hit;
    end
  end
endmodule

// File: rtl/cfv_packer.sv
module cfv_packer #(
  parameter int XLEN  = 64,
  parameter int MAXVL = 8,
  localparam int VLW  = $clog2(MAXVL),
  localparam int LW   = $clog2(XLEN) + 1
) (
  input  logic [XLEN-1:0] word_in,
  input  logic [VLW-1:0]  idx,
  input  logic [1:0]      pack_sel,
  input  logic            en,
  input  logic            bit_val,
  output logic [XLEN-1:0] word_out
);
  for (genvar b = 0; b < XLEN; b++) begin : g_bit
    logic [LW-1:0] lane;
    assign lane        = LW'(b) >> pack_sel;
    assign word_out[b] = (en && lane == LW'(idx)) ? bit_val : word_in[b];
  end
endmodule

// File: rtl/cfv_seq.sv
module cfv_seq
  import cfv_pkg::*;
#(
  parameter int NFLD  = 16,
  parameter int FW    = 4,
  parameter int XLEN  = 64,
  parameter int MAXVL = 8,
  localparam int IDXW = $clog2(NFLD),
  localparam int VLW  = $clog2(MAXVL)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir_expand,
  input  logic [IDXW-1:0]  base_fld,
  input  logic [VLW-1:0]   vl_m1,
  input  logic [FW-1:0]    mask,
  input  logic [FW-1:0]    mode,
  input  logic [1:0]       pack_sel,
  input  logic [1:0]       ew_sel,
  input  logic [MAXVL-1:0] pred,
  input  logic             zero_en,
  input  logic [XLEN-1:0]  int_src,
  input  logic [NFLD*FW-1:0] fld_all,
  output logic             busy,
  output logic             fw_en,
  output logic [IDXW-1:0]  fw_idx,
  output logic [FW-1:0]    fw_data,
  output logic [XLEN-1:0]  int_res,
  output logic             done,
  output logic             ovf
);
  localparam int UW = $clog2(XLEN) + 2;

  logic             load;
  logic [VLW-1:0]   idx;
  dir_e             dir_q;
  logic [IDXW-1:0]  base_q;
  logic [FW-1:0]    mask_q, mode_q;
  logic [1:0]       pack_q, ew_q;
  logic [MAXVL-1:0] pred_q;
  logic             zero_q;
  logic [XLEN-1:0]  src_q;
  logic [XLEN-1:0]  int_q;
  logic             ovf_q;

  cfv_ctrl #(.MAXVL(MAXVL)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .vl_m1(vl_m1),
    .load(load), .busy(busy), .idx(idx), .done(done)
  );

  // load-time overflow and kept-bit window
  logic [3:0]      cl;
  logic            ovf_d;
  logic [UW-1:0]   n_fit;
  logic [UW-1:0]   used;
  logic [XLEN-1:0] keep;

  assign cl    = cap_log2(ew_sel, pack_sel);
  assign ovf_d = (vl_m1 >> cl) != '0;
  assign n_fit = ovf_d ? (UW'(1) << cl) : (UW'(vl_m1) + UW'(1));
  assign used  = n_fit << pack_sel;

  always_comb begin
    for (int b = 0; b < XLEN; b++) keep[b] = UW'(b) < used;
  end

  // per-element datapath
  logic [FW-1:0] cur_fld;
  logic          e_wr, e_ins, e_bit;
  logic [FW-1:0] e_data;
  logic [XLEN-1:0] packed_w;

  assign fw_idx  = base_q + IDXW'(idx);
  assign cur_fld = fld_all[fw_idx*FW +: FW];

  cfv_elem #(.FW(FW), .XLEN(XLEN), .MAXVL(MAXVL)) u_elem (
    .dir(dir_q), .pack_sel(pack_q), .ew_sel(ew_q), .idx(idx),
    .pred_bit(pred_q[idx]), .zero_en(zero_q), .mask(mask_q), .mode(mode_q),
    .fld(cur_fld), .src(src_q), .wr_en(e_wr), .wr_data(e_data),
    .ins_en(e_ins), .ins_bit(e_bit)
  );

  cfv_packer #(.XLEN(XLEN), .MAXVL(MAXVL)) u_pack (
    .word_in(int_q), .idx(idx), .pack_sel(pack_q), .en(e_ins),
    .bit_val(e_bit), .word_out(packed_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q  <= DIR_GATHER;
      base_q <= '0;
      mask_q <= '0;
      mode_q <= '0;
      pack_q <= '0;
      ew_q   <= '0;
      pred_q <= '0;
      zero_q <= 1'b0;
      src_q  <= '0;
      int_q  <= '0;
      ovf_q  <= 1'b0;
    end else if (load) begin
      dir_q  <= dir_e'(dir_expand);
      base_q <= base_fld;
      mask_q <= mask;
      mode_q <= mode;
      pack_q <= pack_sel;
      ew_q   <= ew_sel;
      pred_q <= pred;
      zero_q <= zero_en;
      src_q  <= int_src;
      int_q  <= dir_expand ? '0 : (int_src & keep);
      ovf_q  <= ovf_d;
    end else if (busy && dir_q == DIR_GATHER) begin
      int_q <= packed_w;
    end
  end

  assign fw_en   = busy && e_wr;
  assign fw_data = e_data;
  assign int_res = int_q;
  assign ovf     = ovf_q;
endmodule

// File: rtl/cfv_seq_chk.sv
module cfv_seq_chk #(
  parameter int FW   = 4,
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic            fw_en,
  input logic [FW-1:0]   fw_data,
  input logic            ovf,
  input logic [XLEN-1:0] int_res,
  input logic            cfg_dir,
  input logic [FW-1:0]   cfg_mask,
  input logic [1:0]      cfg_ew
);
  logic [7:0] ew_bits;
  assign ew_bits = 8'd8 << cfg_ew;

  p_done_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_busy_from_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
  p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(ovf));
  p_ew_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !cfg_dir) |-> ((int_res >> ew_bits) == '0));
  p_write_in_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fw_en |-> ((fw_data & ~cfg_mask) == '0));
  p_write_expand_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fw_en |-> (busy && cfg_dir));
  p_expand_int_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dir && (busy || done)) |-> (int_res == '0));
endmodule

bind cfv_seq cfv_seq_chk #(.FW(FW), .XLEN(XLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .fw_en(fw_en), .fw_data(fw_data), .ovf(ovf), .int_res(int_res),
  .cfg_dir(dir_q), .cfg_mask(mask_q), .cfg_ew(ew_q)
);

// File: tb/cfv_seq_tb.sv
module cfv_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, dir_expand = 1'b0;
  logic [3:0] base_fld = '0, mask = '0, mode = '0;
  logic [2:0] vl_m1 = '0;
  logic [1:0] pack_sel = '0, ew_sel = '0;
  logic [7:0] pred = '0;
  logic zero_en = 1'b0;
  logic [63:0] int_src = '0, fld_all = '0;
  logic busy, fw_en, done, ovf;
  logic [3:0] fw_idx, fw_data;
  logic [63:0] int_res;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfv_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .dir_expand(dir_expand),
    .base_fld(base_fld), .vl_m1(vl_m1), .mask(mask), .mode(mode),
    .pack_sel(pack_sel), .ew_sel(ew_sel), .pred(pred), .zero_en(zero_en),
    .int_src(int_src), .fld_all(fld_all), .busy(busy), .fw_en(fw_en),
    .fw_idx(fw_idx), .fw_data(fw_data), .int_res(int_res), .done(done),
    .ovf(ovf)
  );

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] mix(input int k);
    logic [63:0] x;
    x = 64'(k) * 64'h9E3779B97F4A7C15;
    x = x ^ (x >> 29);
    x = x * 64'hBF58476D1CE4E5B9;
    return x ^ (x >> 32);
  endfunction

  task automatic run_op(input bit dx, input int ps, input int es, input int vl,
                        input int base, input logic [3:0] mk, input logic [3:0] md,
                        input logic [7:0] pr, input bit ze, input logic [63:0] src,
                        input logic [63:0] flds, input bit inject);
    int P, EW, cap, n, used;
    logic [63:0] pm, exp_int, keep;
    bit exp_ovf;
    P = 1 << ps; EW = 8 << es; cap = EW / P;
    n = (vl < cap) ? vl : cap;
    exp_ovf = vl > cap;
    used = n * P;
    pm = (P == 64) ? '1 : ((64'd1 << P) - 1);
    keep = (used >= 64) ? '1 : ((64'd1 << used) - 1);
    exp_int = src & keep;
    for (int i = 0; i < n; i++) begin
      logic [3:0] f;
      bit t;
      f = flds[((base + i) % 16) * 4 +: 4];
      t = |(mk & ~(f ^ md));
      if (pr[i] || ze)
        exp_int = (exp_int & ~(pm << (i*P))) | (((pr[i] && t) ? pm : 64'd0) << (i*P));
    end
    if (dx) exp_int = '0;

    @(negedge clk);
    dir_expand = dx; pack_sel = 2'(ps); ew_sel = 2'(es); vl_m1 = 3'(vl - 1);
    base_fld = 4'(base); mask = mk; mode = md; pred = pr; zero_en = ze;
    int_src = src; fld_all = flds; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < vl; i++) begin
      bit xen;
      logic [3:0] xdat;
      logic [63:0] lane;
      lane = (src >> (i*P)) & pm;
      xen  = dx && (i < n) && (pr[i] || ze);
      xdat = pr[i] ? (mk & ((lane != 0) ? md : ~md)) : 4'd0;
      check(busy == 1'b1 && done == 1'b0, "R1 busy during loop", {busy, done}, 2'b10);
      check(ovf == exp_ovf, "R3 ovf", ovf, exp_ovf);
      check(fw_en == xen, dx ? ((i >= n) ? "R3 discard" : "R8 write enable") : "R4 no write in gather",
            fw_en, xen);
      if (xen) begin
        check(fw_idx == 4'((base + i) % 16), "R9 field index", fw_idx, 4'((base + i) % 16));
        check(fw_data == xdat, pr[i] ? "R7 expand data" : "R8 zeroed data", fw_data, xdat);
      end
      if (dx) check(int_res == '0, "R10 expand int", int_res, 0);
      if (inject && i == 0) begin
        start = 1'b1; mask = ~mk; pred = ~pr; base_fld = 4'(base + 3);
        dir_expand = ~dx; vl_m1 = 3'd0;
      end
      if (inject && i == 1) start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    check(done == 1'b1 && busy == 1'b0, "R1 done pulse", {busy, done}, 2'b01);
    check(int_res == exp_int, dx ? "R10 expand int" : "R4 R5 R6 gather result", int_res, exp_int);
    check(ovf == exp_ovf, "R3 ovf at done", ovf, exp_ovf);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, inject ? "R2 start ignored" : "R1 done one cycle",
          {busy, done}, 2'b00);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, fw_en, ovf} == 4'b0 && int_res == '0, "R11 reset state",
          {busy, done, fw_en, ovf}, 0);

    // R7 R8 R9: two-element expand from a zero source with zeroing
    run_op(1'b1, 0, 3, 2, 8, 4'b0011, 4'b0000, 8'b10, 1'b1, 64'd0, mix(7), 1'b0);
    // R9: wrap past the last field
    run_op(1'b1, 0, 3, 3, 15, 4'b1111, 4'b0101, 8'b111, 1'b0, 64'b010, mix(8), 1'b0);
    // R2: start and changed inputs while busy
    run_op(1'b0, 1, 2, 5, 3, 4'b1010, 4'b0110, 8'b10110, 1'b0, mix(9), mix(10), 1'b1);
    run_op(1'b1, 0, 3, 6, 2, 4'b0111, 4'b0001, 8'b101101, 1'b1, mix(11), mix(12), 1'b1);

    // R3 R4 R5 R6 R7 R8: sweep of direction, lane width, element width, VL, zeroing
    k = 0;
    for (int dx = 0; dx < 2; dx++)
      for (int ps = 0; ps < 4; ps++)
        for (int es = 0; es < 4; es++)
          for (int vl = 1; vl <= 8; vl++)
            for (int pat = 0; pat < 4; pat++) begin
              logic [63:0] r;
              r = mix(k + 100);
              run_op(dx[0], ps, es, vl, k % 16, r[3:0], r[7:4], r[15:8], pat[0],
                     pat[1] ? mix(k + 5000) : 64'd0, mix(k + 9000), 1'b0);
              k++;
            end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule